// File: doc/BRIEF.md
# Pointer-Register Data Address Generator

This unit computes the byte address for data loads and stores, and for constant reads from program memory. It owns the six byte registers that form three 16-bit pointers, called X, Y and Z. Each pointer is two byte registers, with the high byte in the odd slot. An operation starts with a one-cycle `start` strobe. On the next clock edge the unit presents the address, a flag saying which memory space the address belongs to, and any pointer write-back.

The unit supports several addressing modes. An absolute mode takes its address from the instruction's second word. Plain indirect uses a pointer as the address. Displacement mode adds a 6-bit unsigned offset to Y or Z. Pre-decrement lowers the pointer first and then addresses with the lowered value. Post-increment addresses with the current value and then raises the pointer. A constant-read mode addresses program memory through Z. The register file writes the pointer bytes through a byte write port. Mode codes and pointer selects that are not defined are ignored.

Top module: `ptr_addr_gen`

## Requirements
- R1: After reset, all six pointer bytes read zero and `addr_valid` and `wb_valid` are low.
- R2: Mode code 0 (absolute) gives `addr = direct_word` one cycle after `start`, with `space_prog` = 0 and no write-back.
- R3: Mode code 1 (indirect) addresses with the pointer chosen by `ptr_sel` (0 = X, 1 = Y, 2 = Z) and leaves every pointer unchanged.
- R4: Mode code 2 (displacement) addresses with Y + `disp` when `disp_z` = 0, or Z + `disp` when `disp_z` = 1. The offset is zero-extended, the sum wraps modulo 2^16, and no pointer changes.
- R5: Mode code 3 (pre-decrement) addresses with pointer−1 and writes pointer−1 back, so 0x0000 becomes 0xFFFF.
- R6: Mode code 4 (post-increment) addresses with the old pointer and writes pointer+1 back, so 0xFFFF becomes 0x0000.
- R7: Mode code 5 (constant read) addresses with Z, sets `space_prog` = 1 and does not modify Z.
- R8: A pointer write-back updates both bytes of the pair on the same edge that issues the address. While `wb_valid` is high, `wb_sel` and `wb_value` match the updated pointer outputs.
- R9: Mode codes 6 and 7, and `ptr_sel` = 3 in modes 1, 3 and 4, produce no address and no write-back. With no `start`, `addr_valid` is low.
- R10: `reg_idx` 0..5 selects X low, X high, Y low, Y high, Z low and Z high. Values 6 and 7 are ignored. If a write-back changes the same byte on the same edge, the write-back wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an address operation |
| mode | input | 3 | Addressing mode code |
| ptr_sel | input | 2 | Pointer select for indirect, pre-decrement and post-increment |
| disp_z | input | 1 | Base for displacement mode: 0 = Y, 1 = Z |
| disp | input | 6 | Unsigned displacement |
| direct_word | input | 16 | Absolute address from the second instruction word |
| reg_we | input | 1 | Pointer byte write enable |
| reg_idx | input | 3 | Pointer byte index |
| reg_wdata | input | 8 | Pointer byte data |
| addr_valid | output | 1 | Address valid this cycle |
| addr | output | 16 | Generated address |
| space_prog | output | 1 | 1 = program memory, 0 = data memory |
| wb_valid | output | 1 | A pointer was updated |
| wb_sel | output | 2 | Updated pointer (0 = X, 1 = Y, 2 = Z) |
| wb_value | output | 16 | New pointer value |
| ptr_x | output | 16 | X pointer |
| ptr_y | output | 16 | Y pointer |
| ptr_z | output | 16 | Z pointer |

## Verification
The assertions check on every cycle that these hold:
- A write-back never appears without an address.
- A write-back value equals either the address or the address plus one.
- The written-back pointer is visible on its output in the same cycle.
- Absolute, plain, constant-read and idle cycles cause no write-back.

The bench's behavioural model, run through directed and random sequences, is needed to show the rest:
- the actual address arithmetic, including wrap at both ends of the 16-bit range;
- the choice of base in displacement mode;
- the byte mapping of the write port;
- the rule for a register write that collides with a write-back.

// File: rtl/ptr_addr_gen.sv
module ptr_addr_gen #(
  parameter int BYTE_W = 8,
  parameter int DISP_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [2:0]          mode,
  input  logic [1:0]          ptr_sel,
  input  logic                disp_z,
  input  logic [DISP_W-1:0]   disp,
  input  logic [2*BYTE_W-1:0] direct_word,
  input  logic                reg_we,
  input  logic [2:0]          reg_idx,
  input  logic [BYTE_W-1:0]   reg_wdata,
  output logic                addr_valid,
  output logic [2*BYTE_W-1:0] addr,
  output logic                space_prog,
  output logic                wb_valid,
  output logic [1:0]          wb_sel,
  output logic [2*BYTE_W-1:0] wb_value,
  output logic [2*BYTE_W-1:0] ptr_x,
  output logic [2*BYTE_W-1:0] ptr_y,
  output logic [2*BYTE_W-1:0] ptr_z
);
  localparam int AW = 2 * BYTE_W;
  localparam int NBYTES = 6;
  localparam logic [2:0] M_ABS = 3'd0, M_IND = 3'd1, M_DSP = 3'd2,
                         M_PRE = 3'd3, M_POST = 3'd4, M_CONST = 3'd5;

  logic [BYTE_W-1:0] rb [NBYTES];
  logic [AW-1:0] cur, base, calc_addr, new_ptr;
  logic ok, upd, prog, go;

  assign ptr_x = {rb[1], rb[0]};
  assign ptr_y = {rb[3], rb[2]};
  assign ptr_z = {rb[5], rb[4]};

  assign cur  = (ptr_sel == 2'd0) ? ptr_x : (ptr_sel == 2'd1) ? ptr_y : ptr_z;
  assign base = disp_z ? ptr_z : ptr_y;

  always_comb begin
    ok = 1'b0;
    upd = 1'b0;
    prog = 1'b0;
    calc_addr = cur;
    new_ptr = cur;
    case (mode)
      M_ABS:   begin ok = 1'b1; calc_addr = direct_word; end
      M_IND:   ok = (ptr_sel != 2'd3);
      M_DSP:   begin ok = 1'b1; calc_addr = base + AW'(disp); end
      M_PRE:   begin ok = (ptr_sel != 2'd3); upd = 1'b1;
                     calc_addr = cur - 1'b1; new_ptr = cur - 1'b1; end
      M_POST:  begin ok = (ptr_sel != 2'd3); upd = 1'b1;
                     new_ptr = cur + 1'b1; end
      M_CONST: begin ok = 1'b1; prog = 1'b1; calc_addr = ptr_z; end
      default: ok = 1'b0;
    endcase
  end

  assign go = start && ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_valid <= 1'b0;
      addr       <= '0;
      space_prog <= 1'b0;
      wb_valid   <= 1'b0;
      wb_sel     <= 2'd0;
      wb_value   <= '0;
    end else begin
      addr_valid <= go;
      wb_valid   <= go && upd;
      if (go) begin
        addr       <= calc_addr;
        space_prog <= prog;
      end
      if (go && upd) begin
        wb_sel   <= ptr_sel;
        wb_value <= new_ptr;
      end
    end
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)
        rb[i] <= '0;
      else if (go && upd && ptr_sel == 2'(i / 2))
        rb[i] <= (i % 2 == 1) ? new_ptr[AW-1:BYTE_W] : new_ptr[BYTE_W-1:0];
      else if (reg_we && reg_idx == 3'(i))
        rb[i] <= reg_wdata;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(!rst_n) |-> (!addr_valid && !wb_valid));

  assert_abs_no_wb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode == M_ABS) |=> (addr_valid && !wb_valid && !space_prog && addr == $past(direct_word)));

  assert_plain_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (mode == M_IND || mode == M_DSP)) |=> !wb_valid);

  assert_wb_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_value == addr || wb_value == addr + 1'b1));

  assert_const_prog_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && space_prog) |-> !wb_valid);

  assert_wb_with_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> addr_valid);

  assert_wb_visible_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wb_value == ((wb_sel == 2'd0) ? ptr_x : (wb_sel == 2'd1) ? ptr_y : ptr_z));

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (!addr_valid && !wb_valid));
endmodule

// File: tb/ptr_addr_gen_test.sv
module ptr_addr_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, disp_z = 0, reg_we = 0;
  logic [2:0] mode = 0, reg_idx = 0;
  logic [1:0] ptr_sel = 0;
  logic [5:0] disp = 0;
  logic [15:0] direct_word = 0;
  logic [7:0] reg_wdata = 0;
  logic addr_valid, space_prog, wb_valid;
  logic [15:0] addr, wb_value, ptr_x, ptr_y, ptr_z;
  logic [1:0] wb_sel;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  ptr_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .ptr_sel(ptr_sel),
    .disp_z(disp_z), .disp(disp), .direct_word(direct_word), .reg_we(reg_we),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .addr_valid(addr_valid), .addr(addr),
    .space_prog(space_prog), .wb_valid(wb_valid), .wb_sel(wb_sel), .wb_value(wb_value),
    .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z));

  int mp[3];
  int e_valid, e_addr, e_prog, e_wb, e_sel, e_wbv;

  always @(posedge clk) begin
    if (!rst_n) begin
      mp[0] = 0; mp[1] = 0; mp[2] = 0;
      e_valid = 0; e_wb = 0;
    end else begin
      int s, p, a, np, doit, upd;
      s = int'(ptr_sel);
      p = (s < 3) ? mp[s] : 0;
      doit = 0; upd = 0; a = 0; np = p;
      if (start) begin
        if (mode == 0) begin doit = 1; a = int'(direct_word); end
        else if (mode == 1 && s < 3) begin doit = 1; a = p; end
        else if (mode == 2) begin doit = 1; a = ((disp_z ? mp[2] : mp[1]) + int'(disp)) % 65536; end
        else if (mode == 3 && s < 3) begin doit = 1; upd = 1; np = (p + 65535) % 65536; a = np; end
        else if (mode == 4 && s < 3) begin doit = 1; upd = 1; a = p; np = (p + 1) % 65536; end
        else if (mode == 5) begin doit = 1; a = mp[2]; end
      end
      e_valid = doit;
      e_wb = upd;
      if (doit) begin e_addr = a; e_prog = (mode == 5) ? 1 : 0; end
      if (upd) begin e_sel = s; e_wbv = np; end
      if (reg_we && reg_idx < 6) begin
        int w;
        w = int'(reg_idx) / 2;
        if (reg_idx % 2 == 1) mp[w] = (mp[w] % 256) + 256 * int'(reg_wdata);
        else mp[w] = (mp[w] / 256) * 256 + int'(reg_wdata);
      end
      if (upd) mp[s] = np;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(int'(addr_valid) == e_valid, cur_req, "addr_valid", int'(addr_valid), e_valid);
      if (e_valid) begin
        chk(int'(addr) == e_addr, cur_req, "addr", int'(addr), e_addr);
        chk(int'(space_prog) == e_prog, cur_req, "space_prog", int'(space_prog), e_prog);
      end
      chk(int'(wb_valid) == e_wb, cur_req, "wb_valid", int'(wb_valid), e_wb);
      if (e_wb) begin
        chk(int'(wb_sel) == e_sel, "R8", "wb_sel", int'(wb_sel), e_sel);
        chk(int'(wb_value) == e_wbv, "R8", "wb_value", int'(wb_value), e_wbv);
      end
      chk(int'(ptr_x) == mp[0], cur_req, "ptr_x", int'(ptr_x), mp[0]);
      chk(int'(ptr_y) == mp[1], cur_req, "ptr_y", int'(ptr_y), mp[1]);
      chk(int'(ptr_z) == mp[2], cur_req, "ptr_z", int'(ptr_z), mp[2]);
    end
  end

  task automatic wr(input int idx, input int val);
    @(negedge clk);
    reg_we = 1; reg_idx = 3'(idx); reg_wdata = 8'(val);
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic setp(input int w, input int val);
    wr(2*w, val % 256);
    wr(2*w + 1, val / 256);
  endtask

  task automatic op(input int m, input int s, input int dz, input int d, input int dw);
    @(negedge clk);
    start = 1; mode = 3'(m); ptr_sel = 2'(s); disp_z = dz[0]; disp = 6'(d); direct_word = 16'(dw);
    @(negedge clk);
    start = 0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    chk(ptr_x == 0 && ptr_y == 0 && ptr_z == 0, "R1", "pointers after reset", int'(ptr_x | ptr_y | ptr_z), 0);
    chk(!addr_valid && !wb_valid, "R1", "strobes after reset", int'({addr_valid, wb_valid}), 0);

    cur_req = "R10";
    setp(0, 16'h1234); setp(1, 16'h8000); setp(2, 16'hFFF0);
    wr(6, 8'hAA); wr(7, 8'h55);
    chk(ptr_x == 16'h1234, "R10", "X byte map", int'(ptr_x), 16'h1234);
    chk(ptr_z == 16'hFFF0, "R10", "Z byte map", int'(ptr_z), 16'hFFF0);

    cur_req = "R2";
    op(0, 0, 0, 0, 16'hBEEF); op(0, 3, 0, 0, 16'h0000);
    cur_req = "R3";
    for (int s = 0; s < 3; s++) op(1, s, 0, 0, 0);
    chk(ptr_y == 16'h8000, "R3", "Y unchanged", int'(ptr_y), 16'h8000);
    cur_req = "R4";
    op(2, 0, 0, 63, 0); op(2, 2, 1, 17, 0); op(2, 1, 1, 31, 0);
    cur_req = "R5";
    setp(0, 0); op(3, 0, 0, 0, 0);
    chk(ptr_x == 16'hFFFF, "R5", "pre-decrement wrap", int'(ptr_x), 16'hFFFF);
    op(3, 1, 0, 0, 0);
    chk(ptr_y == 16'h7FFF, "R5", "Y after pre-decrement", int'(ptr_y), 16'h7FFF);
    cur_req = "R6";
    op(4, 0, 0, 0, 0);
    chk(ptr_x == 16'h0000, "R6", "post-increment wrap", int'(ptr_x), 0);
    op(4, 2, 0, 0, 0); op(4, 2, 0, 0, 0);
    cur_req = "R7";
    op(5, 0, 0, 0, 0);
    chk(ptr_z == 16'hFFF2, "R7", "Z unchanged by constant read", int'(ptr_z), 16'hFFF2);
    cur_req = "R9";
    op(6, 0, 0, 0, 0); op(7, 1, 0, 0, 0); op(1, 3, 0, 0, 0); op(3, 3, 0, 0, 0); op(4, 3, 0, 0, 0);
    chk(ptr_x == 0 && ptr_y == 16'h7FFF, "R9", "no change on ignored ops", int'(ptr_y), 16'h7FFF);

    cur_req = "R10";
    @(negedge clk);
    start = 1; mode = 3'd4; ptr_sel = 2'd1; reg_we = 1; reg_idx = 3'd2; reg_wdata = 8'h11;
    @(negedge clk);
    start = 0; reg_we = 0;
    chk(ptr_y == 16'h8000, "R10", "write-back beats byte write", int'(ptr_y), 16'h8000);

    cur_req = "R8";
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      start = 1'($urandom_range(0, 1));
      mode = 3'($urandom_range(0, 7));
      ptr_sel = 2'($urandom_range(0, 3));
      disp_z = 1'($urandom_range(0, 1));
      disp = 6'($urandom);
      direct_word = 16'($urandom);
      reg_we = ($urandom_range(0, 3) == 0);
      reg_idx = 3'($urandom_range(0, 7));
      reg_wdata = 8'($urandom);
    end
    @(negedge clk);
    start = 0; reg_we = 0;
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule